// File: doc/BRIEF.md
# Condition Flag Update Unit

This block holds the four condition flags of a processor's status word (negative, zero, carry, overflow). It works out their next values after each data-processing operation. The datapath gives it four things: the operation's result, a class code for the operation, the carry-or-borrow bit from the adder, and the operand sign bits. It also gives it the last bit shifted out by the shifter, a set-flags qualifier, a compare/test marker and the destination register index. The adder and the shifter are outside this block.

A flag-setting operation aimed at register index 15 computes no new flags. Instead, the block raises a request to copy the saved status word into the current one. A separate full-load port writes all four flags at once when software writes the status word. That load wins over any value the block computes in the same cycle. The flag register changes only on a clock edge where either an accepted operation or a load is present.

Top module: `flagu_top`

## Requirements
- R1: While reset is asserted and after it is released, `flags` is 4'b0000 until the first update. The flag order is bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V.
- R2: For the add, subtract, shifted-logical and plain-logical classes, an update sets N to `res[31]` and sets Z to 1 exactly when `res` is zero.
- R3: For class 0 (add), C is `ad_cb`, read as the carry out of bit 31. V is 1 exactly when the two operand signs are equal and the sign of `res` differs from them.
- R4: For class 1 (subtract), `ad_cb` is the borrow and C is its inverse. V is 1 exactly when the operand signs differ and the sign of `res` differs from `a_msb`.
- R5: For class 2 (logical with shift), C is `sh_co` and V keeps its value. For class 3 (logical, no shift), C and V both keep their values.
- R6: For class 4 (flag-preserving) and for codes 5 to 7, no flag changes.
- R7: Flags update on a clock edge only when `op_vld` is high and either `cmp_op` or `set_s` is high. Otherwise they hold.
- R8: When `op_vld` and `set_s` are high, `cmp_op` is low and `dst_idx` is 15, `restore_req` is high in that same cycle and the flags hold. A compare ignores `dst_idx`. `restore_req` is low at all other times.
- R9: When `ld_en` is high, the next edge writes `ld_flags` into `flags`, whatever `op_vld` and the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | An operation is presented this cycle |
| op_cls | input | 3 | Class: 0 add, 1 subtract, 2 logical with shift, 3 logical, 4 flag-preserving |
| cmp_op | input | 1 | Compare/test operation, always sets flags |
| set_s | input | 1 | Set-flags qualifier |
| dst_idx | input | 4 | Destination register index |
| res | input | 32 | Operation result |
| ad_cb | input | 1 | Adder carry out (add) or borrow (subtract) |
| a_msb | input | 1 | Sign bit of the first operand |
| b_msb | input | 1 | Sign bit of the second operand |
| sh_co | input | 1 | Last bit shifted out by the shifter |
| ld_en | input | 1 | Full flag load |
| ld_flags | input | 4 | Value for the full load, order N Z C V |
| flags | output | 4 | Current flags, order N Z C V |
| restore_req | output | 1 | Request to copy the saved status word |

## Verification
Additions are driven with a zero result plus carry, and with positive operands that overflow into a negative result. These separate Z, C and V from each other. Subtractions are run with and without a borrow, and with mixed signs, to show that C is the inverse of the borrow and that the subtract overflow formula differs from the add one. The logical, preserving and unqualified operations first set a known value in C and V, then show that the bits meant to hold really do hold. The destination-15 and full-load cases are presented together with operations that would otherwise change the flags, so that both the suppression and the priority are visible.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_LSH  = 3'd2,
    OPC_LOG  = 3'd3,
    OPC_KEEP = 3'd4
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // signed overflow of a + b, from sign bits only
  function automatic logic fn_add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // signed overflow of a - b, from sign bits only
  function automatic logic fn_sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/flagu_calc.sv
module flagu_calc
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic [2:0]        op_cls,
  input  logic              ad_cb,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic              sh_co,
  input  flags_t            cur,
  output flags_t            nxt
);
  localparam int MSB = DATA_W - 1;

  logic res_neg;
  logic res_zero;

  assign res_neg  = res[MSB];
  assign res_zero = (res == '0);

  always_comb begin
    nxt = cur;
    case (opc_e'(op_cls))
      OPC_ADD: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
        nxt.c = ad_cb;
        nxt.v = fn_add_ovf(a_msb, b_msb, res_neg);
      end
      OPC_SUB: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
        nxt.c = ~ad_cb;
        nxt.v = fn_sub_ovf(a_msb, b_msb, res_neg);
      end
      OPC_LSH: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
        nxt.c = sh_co;
      end
      OPC_LOG: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/flagu_gate.sv
module flagu_gate #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             op_vld,
  input  logic             cmp_op,
  input  logic             set_s,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             upd_go,
  output logic             restore_req
);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic wr_req;
  logic to_pc;

  assign wr_req      = op_vld && (cmp_op || set_s);
  assign to_pc       = !cmp_op && (dst_idx == PC_SEL);
  assign restore_req = wr_req && to_pc;
  assign upd_go      = wr_req && !to_pc;
endmodule

// File: rtl/flagu_top.sv
module flagu_top
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_vld,
  input  logic [2:0]        op_cls,
  input  logic              cmp_op,
  input  logic              set_s,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] res,
  input  logic              ad_cb,
  input  logic              a_msb,
  input  logic              b_msb,
  input  logic              sh_co,
  input  logic              ld_en,
  input  logic [3:0]        ld_flags,
  output logic [3:0]        flags,
  output logic              restore_req
);
  flags_t flg_q;
  flags_t flg_nxt;
  logic   upd_go;

  flagu_calc #(.DATA_W(DATA_W)) u_calc (
    .res    (res),
    .op_cls (op_cls),
    .ad_cb  (ad_cb),
    .a_msb  (a_msb),
    .b_msb  (b_msb),
    .sh_co  (sh_co),
    .cur    (flg_q),
    .nxt    (flg_nxt)
  );

  flagu_gate #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_gate (
    .op_vld      (op_vld),
    .cmp_op      (cmp_op),
    .set_s       (set_s),
    .dst_idx     (dst_idx),
    .upd_go      (upd_go),
    .restore_req (restore_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (ld_en)  flg_q <= flags_t'(ld_flags);
    else if (upd_go) flg_q <= flg_nxt;
  end

  assign flags = flg_q;
endmodule

// File: rtl/flagu_chk.sv
module flagu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_vld,
  input logic [2:0]        op_cls,
  input logic              cmp_op,
  input logic              set_s,
  input logic [DATA_W-1:0] res,
  input logic              ld_en,
  input logic [3:0]        ld_flags,
  input logic [3:0]        flags,
  input logic              restore_req,
  input logic              upd_go
);
  logic data_cls;
  assign data_cls = (op_cls <= 3'd3);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> flags == 4'b0000); // R1
  AST_NZ_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && data_cls && !ld_en) |=> (flags[3] == $past(res[DATA_W-1])) && (flags[2] == ($past(res) == '0))); // R2
  AST_LOGIC_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && (op_cls == 3'd2 || op_cls == 3'd3) && !ld_en) |=> $stable(flags[0])); // R5
  AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_cls >= 3'd4 && !ld_en) |=> $stable(flags)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_vld && (cmp_op || set_s)) && !ld_en) |=> $stable(flags)); // R7
  AST_RESTORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !ld_en) |=> $stable(flags)); // R8
  AST_RESTORE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> (op_vld && set_s && !cmp_op && !upd_go)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> flags == $past(ld_flags)); // R9
endmodule

bind flagu_top flagu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_vld      (op_vld),
  .op_cls      (op_cls),
  .cmp_op      (cmp_op),
  .set_s       (set_s),
  .res         (res),
  .ld_en       (ld_en),
  .ld_flags    (ld_flags),
  .flags       (flags),
  .restore_req (restore_req),
  .upd_go      (upd_go)
);

// File: tb/sim_flagu_top.sv
module sim_flagu_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_vld = 1'b0;
  logic [2:0]  op_cls = 3'd0;
  logic        cmp_op = 1'b0;
  logic        set_s = 1'b0;
  logic [3:0]  dst_idx = 4'd0;
  logic [31:0] res = 32'd0;
  logic        ad_cb = 1'b0;
  logic        a_msb = 1'b0;
  logic        b_msb = 1'b0;
  logic        sh_co = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_flags = 4'd0;
  logic [3:0]  flags;
  logic        restore_req;

  int total = 0;
  int bad = 0;
  logic [3:0] mflags = 4'd0;
  logic [3:0] expq[$];
  string      tagq[$];
  logic       running = 1'b0;

  flagu_top u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_cls(op_cls), .cmp_op(cmp_op),
    .set_s(set_s), .dst_idx(dst_idx), .res(res), .ad_cb(ad_cb), .a_msb(a_msb),
    .b_msb(b_msb), .sh_co(sh_co), .ld_en(ld_en), .ld_flags(ld_flags),
    .flags(flags), .restore_req(restore_req)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the flags expected after the edge
  task automatic drive(input string tag, input logic vld, input logic [2:0] cls,
                       input logic cmp, input logic s, input logic [3:0] dst,
                       input logic [31:0] r, input logic cb, input logic sa,
                       input logic sb, input logic sc, input logic ld,
                       input logic [3:0] ldv);
    logic wr, pc, exp_rst;
    logic [3:0] nx;
    @(negedge clk);
    op_vld = vld; op_cls = cls; cmp_op = cmp; set_s = s; dst_idx = dst;
    res = r; ad_cb = cb; a_msb = sa; b_msb = sb; sh_co = sc;
    ld_en = ld; ld_flags = ldv;
    wr = vld & (cmp | s);
    pc = !cmp && (dst == 4'd15);
    exp_rst = wr & pc;
    nx = mflags;
    if (wr && !pc) begin
      if (cls <= 3'd3) begin
        nx[3] = r[31];
        nx[2] = ~|r;
      end
      if (cls == 3'd0) begin
        nx[1] = cb;
        nx[0] = (sa ^ r[31]) & (sb ^ r[31]);
      end else if (cls == 3'd1) begin
        nx[1] = !cb;
        nx[0] = (sa ^ sb) & (sa ^ r[31]);
      end else if (cls == 3'd2) begin
        nx[1] = sc;
      end
    end
    if (ld) nx = ldv;
    #1;
    chk({tag, " restore_req (R8)"}, {3'b000, restore_req}, {3'b000, exp_rst});
    mflags = nx;
    expq.push_back(nx);
    tagq.push_back(tag);
  endtask

  // monitor: after each edge compares flags with the queued expectation
  always @(posedge clk) begin
    #2;
    if (running && expq.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(t, flags, e);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk("R1 flags in reset", flags, 4'b0000);
    chk("R1 restore_req in reset", {3'b000, restore_req}, 4'b0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", flags, 4'b0000);
    running = 1'b1;
    // vld cls cmp s dst res cb sa sb sc ld ldv
    drive("R2 R3 add zero with carry",    1, 3'd0, 0, 1, 4'd2, 32'h0000_0000, 1, 1, 1, 0, 0, 4'h0);
    drive("R3 add signed overflow",       1, 3'd0, 0, 1, 4'd2, 32'h8000_0001, 0, 0, 0, 0, 0, 4'h0);
    drive("R4 sub with borrow",           1, 3'd1, 1, 0, 4'd0, 32'hFFFF_FFFE, 1, 0, 0, 0, 0, 4'h0);
    drive("R4 sub no borrow zero",        1, 3'd1, 1, 0, 4'd0, 32'h0000_0000, 0, 0, 0, 0, 0, 4'h0);
    drive("R4 sub mixed sign overflow",   1, 3'd1, 0, 1, 4'd3, 32'h7FFF_FFF0, 0, 1, 0, 0, 0, 4'h0);
    drive("R3 add sets V for later",      1, 3'd0, 0, 1, 4'd1, 32'h8000_0000, 1, 0, 0, 0, 0, 4'h0);
    drive("R5 logical shift C from shifter", 1, 3'd2, 0, 1, 4'd1, 32'h0000_0010, 1, 1, 1, 0, 0, 4'h0);
    drive("R5 logical plain keeps C V",   1, 3'd3, 1, 0, 4'd1, 32'h8000_0000, 0, 0, 0, 1, 0, 4'h0);
    drive("R6 preserving class holds",    1, 3'd4, 1, 1, 4'd1, 32'h0000_0000, 0, 1, 0, 0, 0, 4'h0);
    drive("R6 code 7 holds",              1, 3'd7, 0, 1, 4'd1, 32'h0000_0000, 0, 1, 0, 0, 0, 4'h0);
    drive("R7 no S no compare holds",     1, 3'd0, 0, 0, 4'd1, 32'h0000_0000, 0, 0, 0, 0, 0, 4'h0);
    drive("R7 op_vld low holds",          0, 3'd1, 1, 1, 4'd1, 32'h0000_0000, 1, 1, 0, 0, 0, 4'h0);
    drive("R8 dest 15 restore no update", 1, 3'd0, 0, 1, 4'd15, 32'h0000_0000, 1, 1, 1, 0, 0, 4'h0);
    drive("R8 compare ignores dest 15",   1, 3'd1, 1, 0, 4'd15, 32'h0000_0000, 1, 0, 0, 0, 0, 4'h0);
    drive("R9 load beats add",            1, 3'd0, 0, 1, 4'd2, 32'h0000_0000, 1, 0, 0, 0, 1, 4'b1010);
    drive("R9 load without op",           0, 3'd0, 0, 0, 4'd0, 32'h0000_0000, 0, 0, 0, 0, 1, 4'b0101);
    drive("R8 R9 load during restore",    1, 3'd0, 0, 1, 4'd15, 32'h0000_0000, 0, 0, 0, 0, 1, 4'b1111);
    drive("R7 idle",                      0, 3'd0, 0, 0, 4'd0, 32'h0000_0000, 0, 0, 0, 0, 0, 4'h0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule